// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is the serial front end of a small register-mapped device. It watches the two bus lines, SCL and SDA, through two-flop synchronisers and finds START and STOP conditions from the synchronised levels. After a START it collects an identification byte. That byte carries a fixed `1010` prefix, then three bits that must equal the strap inputs, then a direction bit. It then takes an address byte into an internal register pointer. On a write it accepts data bytes, one register for each byte. On a read it shifts out register contents. It acknowledges at each point the protocol calls for. The slave drives SDA in open-drain fashion: a single output enable pulls the line low, and with the enable off the line is released.

The register file sits outside the block. It receives a one-cycle write strobe with an address and data. It also returns read data combinationally for the address the block presents. Registers at or above a parameterised base address count as non-volatile. When a write transaction has touched such a register, the STOP that ends it starts an internal write cycle. That cycle is modelled as a counter of a parameterised number of clocks, and a busy output is high while it runs. A power-up interval of its own length follows reset in the same way. While busy is high, every START is ignored.

Top module: `i2c_regslave`

## Requirements
- R1: No byte is acknowledged unless a START (SDA falling while SCL is high) has been seen first. A byte clocked without a START leaves SDA released.
- R2: After a START, an identification byte equal to `1010` followed by `strap_i[2:0]` (bits 7..1) is acknowledged by holding SDA low during the ninth SCL pulse. Bit 0 selects the direction: 0 means write and 1 means read.
- R3: An identification byte whose bits 7..1 do not match is not acknowledged. The slave then ignores the following bytes until the next START.
- R4: In a write transaction, the byte after the identification byte is acknowledged and loads the register pointer.
- R5: Each later write data byte is acknowledged and causes exactly one single-cycle `reg_wr_en` pulse, carrying the current pointer and the byte. The pointer then increments.
- R6: In a read transaction, the slave shifts out `reg_rd_data` for address `reg_rd_addr` (the pointer), MSB first, with one bit per SCL pulse. It releases SDA for the ninth pulse and increments the pointer. A master ACK (SDA low) continues with the next register. A master NACK ends the transfer, and SDA stays released.
- R7: A STOP (SDA rising while SCL is high) after a read, or after a write to volatile registers only (addresses below `NV_BASE`), leaves `busy` low.
- R8: A STOP after a write transaction that wrote any address at or above `NV_BASE` raises `busy` for exactly `NV_CYCLES` clock cycles.
- R9: After reset, `busy` is high for exactly `PWRUP_CYCLES` cycles. A START seen while `busy` is high is ignored, and the following identification byte is not acknowledged.
- R10: A repeated START in the middle of a transaction restarts identification-byte reception, and the register pointer is kept.
- R11: The slave only begins pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level (asynchronous) |
| sda_i | input | 1 | Bus data line level (asynchronous) |
| strap_i | input | 3 | Pin-strapped device address bits |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 8 | Register write address |
| reg_wr_data | output | 8 | Register write data |
| reg_rd_addr | output | 8 | Register read address (the pointer) |
| reg_rd_data | input | 8 | Register read data for `reg_rd_addr` |
| busy | output | 1 | Power-up or non-volatile write cycle running |

## Verification
The bench builds the block with `NV_CYCLES` = 40, `PWRUP_CYCLES` = 30 and `NV_BASE` = 8'hC0. A bus bit lasts about 20 system clocks. With these values a START can be placed inside the power-up window, and another inside the non-volatile write window, straight after the STOP that opens it. The exact lengths of both busy intervals are therefore measured in the same run as the ignored-START checks. The low `NV_BASE` lets one transaction reach the non-volatile range and another stay in the volatile range.

// File: rtl/i2c_regslave_pkg.sv
// Shared types and constants for the serial register slave.
package i2c_regslave_pkg;

    localparam int BYTE_W   = 8;
    localparam int STRAP_W  = 3;
    localparam int PREFIX_W = BYTE_W - 1 - STRAP_W;
    localparam logic [PREFIX_W-1:0] ID_PREFIX = 4'b1010;
    localparam int BITCNT_W = $clog2(BYTE_W + 1);

    // Protocol phases of the slave
    typedef enum logic [3:0] {
        ST_IDLE,      // waiting for START
        ST_DEVID,     // receiving identification byte
        ST_ACK_ID,    // driving ACK for identification byte
        ST_ADDR,      // receiving register address
        ST_ACK_ADDR,  // driving ACK for address
        ST_WDATA,     // receiving write data
        ST_ACK_W,     // driving ACK for write data
        ST_RDATA,     // shifting out read data
        ST_RACK       // sampling master ACK/NACK
    } slv_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronises SCL and SDA with two flops each and derives SCL edges plus
// START/STOP events from the synchronised levels.
// Assumes each bus phase lasts several system clocks; idle bus is high.
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_m, sda_m;
    logic scl_q, sda_q;

    // Two-flop synchronisers followed by one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_m <= 1'b1;
            sda_m <= 1'b1;
            scl_s <= 1'b1;
            sda_s <= 1'b1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_m <= scl_i;
            sda_m <= sda_i;
            scl_s <= scl_m;
            sda_s <= sda_m;
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge and bus-condition decode
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_busy_timer.sv
// Busy interval generator: a power-up interval after reset and a fixed-length
// non-volatile write interval after each start pulse.
// Assumes start pulses arrive only while idle.
module i2c_busy_timer #(
    parameter int NV_CYCLES    = 1000,
    parameter int PWRUP_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nv_start,
    output logic busy
);

    localparam int MAXC  = (NV_CYCLES > PWRUP_CYCLES) ? NV_CYCLES : PWRUP_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt;

    // Load on reset or start, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= CNT_W'(PWRUP_CYCLES);
        else if (nv_start)
            cnt <= CNT_W'(NV_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // A busy interval only opens from a start pulse once out of reset
    assert_busy_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(nv_start));

endmodule

// File: rtl/i2c_proto_fsm.sv
// Byte-level protocol engine: identification match, address pointer, write
// strobes, read shifting, ACK generation and non-volatile tracking.
// Assumes synchronised levels and single-cycle edge/condition pulses.
module i2c_proto_fsm
    import i2c_regslave_pkg::*;
#(
    parameter logic [BYTE_W-1:0] NV_BASE = 8'h80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_s,
    input  logic               sda_s,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               busy,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic [BYTE_W-1:0]  ptr,
    output logic               wr_en,
    output logic [BYTE_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0]  wr_data,
    output logic               sda_oe,
    output logic               nv_start
);

    slv_state_t           state;
    logic [BITCNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0]    shreg;
    logic [BYTE_W-1:0]    txreg;
    logic                 rw_read;
    logic                 mst_ack;
    logic                 nv_dirty;
    logic                 id_match;
    logic                 byte_end;

    // Identification compare and end-of-byte detect
    always_comb begin
        id_match = (shreg[BYTE_W-1:1] == {ID_PREFIX, strap_i});
        byte_end = scl_fall && (bitcnt == BITCNT_W'(BYTE_W));
    end

    // Protocol state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            txreg    <= '0;
            rw_read  <= 1'b0;
            mst_ack  <= 1'b0;
            nv_dirty <= 1'b0;
            ptr      <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            sda_oe   <= 1'b0;
            nv_start <= 1'b0;
        end else begin
            wr_en    <= 1'b0;
            nv_start <= 1'b0;
            if (start_det && !busy) begin
                state  <= ST_DEVID;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_oe   <= 1'b0;
                nv_start <= nv_dirty;
                nv_dirty <= 1'b0;
            end else begin
                case (state)
                    ST_DEVID, ST_ADDR, ST_WDATA: begin
                        if (scl_rise && bitcnt < BITCNT_W'(BYTE_W)) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (byte_end) begin
                            bitcnt <= '0;
                            if (state == ST_DEVID) begin
                                if (id_match) begin
                                    rw_read <= shreg[0];
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ACK_ID;
                                end else begin
                                    state   <= ST_IDLE;
                                end
                            end else if (state == ST_ADDR) begin
                                ptr    <= shreg;
                                sda_oe <= 1'b1;
                                state  <= ST_ACK_ADDR;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                if (ptr >= NV_BASE) nv_dirty <= 1'b1;
                                ptr     <= ptr + 1'b1;
                                sda_oe  <= 1'b1;
                                state   <= ST_ACK_W;
                            end
                        end
                    end
                    ST_ACK_ID: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw_read) begin
                                txreg  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_ADDR;
                            end
                        end
                    end
                    ST_ACK_ADDR, ST_ACK_W: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) bitcnt <= bitcnt + 1'b1;
                        if (scl_fall && bitcnt != '0) begin
                            if (bitcnt == BITCNT_W'(BYTE_W)) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 1'b1;
                                state  <= ST_RACK;
                            end else begin
                                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~txreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) mst_ack <= ~sda_s;
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (mst_ack) begin
                                txreg  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // START during a busy interval leaves the engine idle
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && busy) |=> (state == ST_IDLE));

    // Write strobe is a single cycle
    assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // No register write while a busy interval runs
    assert_no_wr_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !busy);

    // The slave starts pulling SDA only while SCL is low
    assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // A non-volatile cycle is only requested by a STOP
    assert_nv_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nv_start |-> $past(stop_det));

endmodule

// File: rtl/i2c_regslave.sv
// Top level of the serial register slave: line synchroniser, protocol
// engine and busy timer. The register file is external; read data must be
// valid combinationally for reg_rd_addr.
module i2c_regslave
    import i2c_regslave_pkg::*;
#(
    parameter int                NV_CYCLES    = 1000,
    parameter int                PWRUP_CYCLES = 500,
    parameter logic [BYTE_W-1:0] NV_BASE      = 8'h80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_oe,
    output logic               reg_wr_en,
    output logic [BYTE_W-1:0]  reg_wr_addr,
    output logic [BYTE_W-1:0]  reg_wr_data,
    output logic [BYTE_W-1:0]  reg_rd_addr,
    input  logic [BYTE_W-1:0]  reg_rd_data,
    output logic               busy
);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic nv_start;

    i2c_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_proto_fsm #(.NV_BASE(NV_BASE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .busy      (busy),
        .strap_i   (strap_i),
        .rd_data   (reg_rd_data),
        .ptr       (reg_rd_addr),
        .wr_en     (reg_wr_en),
        .wr_addr   (reg_wr_addr),
        .wr_data   (reg_wr_data),
        .sda_oe    (sda_oe),
        .nv_start  (nv_start)
    );

    i2c_busy_timer #(
        .NV_CYCLES    (NV_CYCLES),
        .PWRUP_CYCLES (PWRUP_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .nv_start (nv_start),
        .busy     (busy)
    );

endmodule

// File: tb/sim_i2c_regslave.sv
`timescale 1ns/1ps
module sim_i2c_regslave;

    localparam int NV_C = 40;
    localparam int PU_C = 30;
    localparam int T    = 10;            // system clocks per SCL phase
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] ID_W  = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] ID_R  = {4'b1010, STRAP, 1'b1};
    localparam logic [7:0] ID_BAD = {4'b1010, 3'b001, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, reg_wr_en, busy;
    logic [7:0] reg_wr_addr, reg_wr_data, reg_rd_addr, reg_rd_data;
    logic [7:0] mem [256];
    logic sda_line;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_wr [$];
    int busy_run = 0;
    int last_run = 0;
    int busy_seen = 0;
    int drive_viol = 0;
    logic prev_oe = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    assign sda_line    = sda_m & ~sda_oe;
    assign reg_rd_data = mem[reg_rd_addr];

    i2c_regslave #(.NV_CYCLES(NV_C), .PWRUP_CYCLES(PU_C), .NV_BASE(8'hC0)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .strap_i     (STRAP),
        .sda_oe      (sda_oe),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_addr (reg_rd_addr),
        .reg_rd_data (reg_rd_data),
        .busy        (busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(T); scl_m = 1'b1; wt(T);
        sda_m = 1'b0; wt(T);
        scl_m = 1'b0; wt(T);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(T);
        scl_m = 1'b1; wt(T);
        sda_m = 1'b1; wt(T);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(T);
            scl_m = 1'b1; wt(T);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wt(T);
        scl_m = 1'b1; wt(T/2);
        acked = !sda_line;
        wt(T/2);
        scl_m = 1'b0; wt(1);
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(T);
            scl_m = 1'b1; wt(T/2);
            b[i] = sda_line;
            wt(T/2);
            scl_m = 1'b0;
        end
        wt(T/2);
        sda_m = !give_ack; wt(T/2);
        scl_m = 1'b1; wt(T);
        scl_m = 1'b0; wt(2);
        sda_m = 1'b1;
    endtask

    // Register model and write scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && reg_wr_en) begin
            mem[reg_wr_addr] <= reg_wr_data;
            if (exp_wr.size() == 0) begin
                chk(1'b0, "R5 unexpected write", {reg_wr_addr, reg_wr_data}, 0);
            end else begin
                logic [15:0] e;
                e = exp_wr.pop_front();
                chk({reg_wr_addr, reg_wr_data} == e, "R5 write addr/data",
                    {reg_wr_addr, reg_wr_data}, e);
            end
        end
    end

    // Busy interval measurement and SDA drive timing monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) begin
                busy_run++;
                busy_seen++;
            end else if (busy_run != 0) begin
                last_run = busy_run;
                busy_run = 0;
            end
            if (sda_oe && !prev_oe && scl_m) drive_viol++;
            prev_oe = sda_oe;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] rb;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(sda_oe == 1'b0, "R11 reset sda released", sda_oe, 0);
        chk(reg_wr_en == 1'b0, "R5 reset no write", reg_wr_en, 0);
        chk(busy == 1'b1, "R9 busy after reset", busy, 1);

        // R9: START during power-up is ignored
        bus_start();
        send_byte(ID_W, ack);
        chk(!ack, "R9 start ignored in power-up", ack, 0);
        bus_stop();
        chk(last_run == PU_C, "R9 power-up length", last_run, PU_C);

        // R1: byte without START
        send_byte(ID_W, ack);
        chk(!ack, "R1 no ack without start", ack, 0);
        bus_stop();

        // R3: mismatched identification, following byte also ignored
        bus_start();
        send_byte(ID_BAD, ack);
        chk(!ack, "R3 bad id not acked", ack, 0);
        send_byte(8'h10, ack);
        chk(!ack, "R3 later byte ignored", ack, 0);
        bus_stop();

        // R2/R4/R5: volatile write of two bytes
        busy_seen = 0;
        bus_start();
        send_byte(ID_W, ack);
        chk(ack, "R2 id acked", ack, 1);
        send_byte(8'h10, ack);
        chk(ack, "R4 address acked", ack, 1);
        exp_wr.push_back({8'h10, 8'hA5});
        send_byte(8'hA5, ack);
        chk(ack, "R5 data acked", ack, 1);
        exp_wr.push_back({8'h11, 8'h3C});
        send_byte(8'h3C, ack);
        chk(ack, "R5 second data acked", ack, 1);
        bus_stop();
        wt(60);
        chk(busy_seen == 0, "R7 volatile write no busy", busy_seen, 0);

        // R10/R6: pointer set, repeated START, read with ACK then NACK
        bus_start();
        send_byte(ID_W, ack);
        send_byte(8'h10, ack);
        bus_start();
        send_byte(ID_R, ack);
        chk(ack, "R10 repeated start id acked", ack, 1);
        read_byte(1'b1, rb);
        chk(rb == 8'hA5, "R6 read first byte", rb, 8'hA5);
        read_byte(1'b0, rb);
        chk(rb == 8'h3C, "R6 read second byte", rb, 8'h3C);
        wt(T);
        chk(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
        bus_stop();
        wt(60);
        chk(busy_seen == 0, "R7 read no busy", busy_seen, 0);

        // Read continuing past reset-pattern register
        bus_start();
        send_byte(ID_W, ack);
        send_byte(8'h40, ack);
        bus_start();
        send_byte(ID_R, ack);
        read_byte(1'b1, rb);
        chk(rb == 8'(8'h40 * 7 + 3), "R6 read reg 40", rb, 8'(8'h40 * 7 + 3));
        read_byte(1'b0, rb);
        chk(rb == 8'(8'h41 * 7 + 3), "R6 read reg 41", rb, 8'(8'h41 * 7 + 3));
        bus_stop();

        // R8/R9: non-volatile write, START during busy ignored
        bus_start();
        send_byte(ID_W, ack);
        send_byte(8'hC0, ack);
        exp_wr.push_back({8'hC0, 8'h77});
        send_byte(8'h77, ack);
        chk(ack, "R5 nv data acked", ack, 1);
        bus_stop();
        chk(busy == 1'b1, "R8 busy after nv stop", busy, 1);
        bus_start();
        send_byte(ID_W, ack);
        chk(!ack, "R9 start ignored in nv cycle", ack, 0);
        bus_stop();
        chk(last_run == NV_C, "R8 nv cycle length", last_run, NV_C);
        bus_start();
        send_byte(ID_W, ack);
        chk(ack, "R9 start accepted after busy", ack, 1);
        bus_stop();

        wt(20);
        chk(exp_wr.size() == 0, "R5 all writes seen", exp_wr.size(), 0);
        chk(drive_viol == 0, "R11 drive while scl high", drive_viol, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule